// File: doc/BRIEF.md
# Timer Capture/Compare Channel

One channel of a small timer. The counter is not part of the channel. The channel reads the counter's value from an input and works in one of two modes. In compare mode it drives a pulse-width output by comparing that value with its own compare register. In capture mode it watches an external pin and copies the counter value into the same register whenever a qualified pin event occurs.

In capture mode the pin first goes through a two-flop synchronizer and then a stability filter that can be set to a length. An edge selector follows, and then a decimating prescaler. A capture sets a sticky flag. If a second capture arrives before that flag is cleared, an overrun flag is raised. Software, or any other user, clears both flags with a one-cycle pulse and can load the register directly for compare use.

The asynchronous reset is released through a two-stage synchronizer inside the block, so all state leaves reset two clock edges after the reset input rises.

Top module: `tmr_cc_chan`

## Requirements
- R1: `cfg_mode`=0 selects compare (pulse) mode and `cfg_mode`=1 selects capture mode. While in capture mode, `pwm_out` is held at 0.
- R2: The pin is synchronized by two flops. The filtered level changes only after the new level has been sampled in 2^`cfg_flt` consecutive cycles (1, 2, 4 or 8). A pulse shorter than that is ignored.
- R3: The captured value is the counter value present at the (3+2^`cfg_flt`)-th rising clock edge, counting the first edge that samples the new pin level as edge 1.
- R4: In capture mode, `cfg_pol` selects the events: 00 selects rising edges, 01 selects falling edges, and 1x selects both.
- R5: `cfg_psc` values 0, 1, 2 and 3 capture on every 1st, 2nd, 4th and 8th qualifying event. The first capture after arming falls on that event.
- R6: The event count restarts from zero when the channel is disarmed (`cfg_en`=0 or compare mode) or when `cfg_psc` changes.
- R7: With `cfg_en`=0 no capture happens, `ccr_q` is unchanged and `cap_flag` stays 0.
- R8: Each capture sets `cap_flag` and keeps it set until `flag_clr` is pulsed. If a capture and a clear fall in the same cycle, the capture wins.
- R9: A capture while `cap_flag` is already 1 sets `ovr_flag`. `flag_clr` clears `ovr_flag`.
- R10: In compare mode, `pwm_out` is registered one cycle after the inputs. Its value is (`cnt_val` < `ccr_q`) XOR `cfg_pol[0]`, and `cfg_pol[1]` has no effect on it.
- R11: `ccr_wr` loads `ccr_wdata` into `ccr_q`. A capture in the same cycle takes priority.
- R12: After reset, `ccr_q`, `cap_flag`, `ovr_flag` and `pwm_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | 0 compare, 1 capture |
| cfg_en | input | 1 | Capture enable |
| cfg_pol | input | 2 | Edge select / output polarity |
| cfg_flt | input | 2 | Filter length select |
| cfg_psc | input | 2 | Event prescaler select |
| cnt_val | input | CW | Shared counter value |
| ccr_wr | input | 1 | Register load strobe |
| ccr_wdata | input | CW | Register load data |
| cap_in | input | 1 | External capture pin |
| flag_clr | input | 1 | Clears capture and overrun flags |
| ccr_q | output | CW | Capture/compare register |
| cap_flag | output | 1 | Sticky capture flag |
| ovr_flag | output | 1 | Overrun flag |
| pwm_out | output | 1 | Compare output |

## Verification
The case hardest to reach is a prescaler count left over from earlier events. Leftover counts only show up when a particular number of edges is followed by a change of configuration. The bench sweeps every combination of filter length, prescaler and edge polarity from a disarmed start, predicting each capture arithmetically. It also sends three events at divide-by-8, switches to divide-by-2, and expects no capture until the second new event. Filter boundaries are probed with pulses one cycle shorter than the programmed length and exactly equal to it.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;
  typedef enum logic {
    CC_MODE_PWM = 1'b0,
    CC_MODE_CAP = 1'b1
  } cc_mode_e;

  localparam int unsigned SEL_W = 2;
  localparam int unsigned CNT_W = 3;

  // count limit for a 2-bit power-of-two select: 0,1,3,7
  function automatic logic [CNT_W-1:0] sel_limit(input logic [SEL_W-1:0] sel);
    return CNT_W'((1 << sel) - 1);
  endfunction
endpackage

// File: rtl/cc_sync_filter.sv
module cc_sync_filter
  import tmr_cc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [SEL_W-1:0] flt_sel,
  output logic             flt_q
);
  logic             s1_q, s2_q;
  logic [CNT_W-1:0] run_q, run_d;
  logic             flt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    run_d = run_q;
    flt_d = flt_q;
    if (s2_q == flt_q) begin
      run_d = '0;
    end else if (run_q >= sel_limit(flt_sel)) begin
      flt_d = s2_q;
      run_d = '0;
    end else begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      flt_q <= 1'b0;
    end else begin
      run_q <= run_d;
      flt_q <= flt_d;
    end
  end

  // R2
  flt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q != $past(flt_q)) |-> ($past(s2_q) == flt_q));
endmodule

// File: rtl/cc_edge_presc.sv
module cc_edge_presc
  import tmr_cc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl,
  input  logic [1:0]       pol,
  input  logic             armed,
  input  logic [SEL_W-1:0] psc_sel,
  output logic             fire
);
  logic             lvl_q;
  logic [SEL_W-1:0] psc_q;
  logic [CNT_W-1:0] ev_q, ev_d;
  logic             rise, fall, evt, restart, at_lim;

  assign rise    = lvl & ~lvl_q;
  assign fall    = ~lvl & lvl_q;
  assign evt     = pol[1] ? (rise | fall) : (pol[0] ? fall : rise);
  assign restart = !armed || (psc_sel != psc_q);
  assign at_lim  = ev_q >= sel_limit(psc_sel);
  assign fire    = !restart && evt && at_lim;

  always_comb begin
    ev_d = ev_q;
    if (restart)     ev_d = '0;
    else if (evt)    ev_d = at_lim ? '0 : ev_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      psc_q <= '0;
      ev_q  <= '0;
    end else begin
      lvl_q <= lvl;
      psc_q <= psc_sel;
      ev_q  <= ev_d;
    end
  end

  // R6
  psc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!armed) |-> (ev_q == '0));
endmodule

// File: rtl/tmr_cc_chan.sv
module tmr_cc_chan
  import tmr_cc_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_mode,
  input  logic          cfg_en,
  input  logic [1:0]    cfg_pol,
  input  logic [1:0]    cfg_flt,
  input  logic [1:0]    cfg_psc,
  input  logic [CW-1:0] cnt_val,
  input  logic          ccr_wr,
  input  logic [CW-1:0] ccr_wdata,
  input  logic          cap_in,
  input  logic          flag_clr,
  output logic [CW-1:0] ccr_q,
  output logic          cap_flag,
  output logic          ovr_flag,
  output logic          pwm_out
);
  logic          rs1_q, rs2_q, rst_int_n;
  logic          flt_lvl, cap_fire, armed, is_cap;
  logic [CW-1:0] ccr_d;
  logic          cap_d, ovr_d, pwm_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_int_n = rs2_q;

  assign is_cap = (cc_mode_e'(cfg_mode) == CC_MODE_CAP);
  assign armed  = is_cap && cfg_en;

  cc_sync_filter u_filt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .din     (cap_in),
    .flt_sel (cfg_flt),
    .flt_q   (flt_lvl)
  );

  cc_edge_presc u_presc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .lvl     (flt_lvl),
    .pol     (cfg_pol),
    .armed   (armed),
    .psc_sel (cfg_psc),
    .fire    (cap_fire)
  );

  always_comb begin
    ccr_d = ccr_q;
    if (cap_fire)    ccr_d = cnt_val;
    else if (ccr_wr) ccr_d = ccr_wdata;

    cap_d = cap_flag;
    ovr_d = ovr_flag;
    if (flag_clr) begin
      cap_d = 1'b0;
      ovr_d = 1'b0;
    end
    if (cap_fire) begin
      cap_d = 1'b1;
      if (cap_flag && !flag_clr) ovr_d = 1'b1;
    end

    pwm_d = is_cap ? 1'b0 : ((cnt_val < ccr_q) ^ cfg_pol[0]);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ccr_q    <= '0;
      cap_flag <= 1'b0;
      ovr_flag <= 1'b0;
      pwm_out  <= 1'b0;
    end else begin
      ccr_q    <= ccr_d;
      cap_flag <= cap_d;
      ovr_flag <= ovr_d;
      pwm_out  <= pwm_d;
    end
  end

  // R7
  ccr_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!$past(cfg_en) && !$past(ccr_wr)) |-> $stable(ccr_q));
  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(cap_flag) |-> $past(cap_fire));
  // R9
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(ovr_flag) |-> $past(cap_flag));
  // R1
  pwm_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(cfg_mode) |-> !pwm_out);
endmodule

// File: tb/tmr_cc_chan_tb.sv
module tmr_cc_chan_tb;
  localparam int CLK_P = 10;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_mode, cfg_en, ccr_wr, cap_in, flag_clr;
  logic [1:0] cfg_pol, cfg_flt, cfg_psc;
  logic [CW-1:0] cnt_val, ccr_wdata;
  logic [CW-1:0] ccr_q;
  logic cap_flag, ovr_flag, pwm_out;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  initial begin
    cnt_val = '0;
    forever @(negedge clk) cnt_val <= cnt_val + 1'b1;
  end

  tmr_cc_chan #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_en(cfg_en),
    .cfg_pol(cfg_pol), .cfg_flt(cfg_flt), .cfg_psc(cfg_psc),
    .cnt_val(cnt_val), .ccr_wr(ccr_wr), .ccr_wdata(ccr_wdata),
    .cap_in(cap_in), .flag_clr(flag_clr), .ccr_q(ccr_q),
    .cap_flag(cap_flag), .ovr_flag(ovr_flag), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_flags();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  task automatic drive_pin(input logic lvl, output logic [CW-1:0] v0);
    @(negedge clk);
    cap_in = lvl;
    v0 = cnt_val;
  endtask

  task automatic disarm_setup(input int f, input int p, input int pl);
    @(negedge clk);
    cfg_en = 1'b0; cfg_mode = 1'b1;
    cfg_flt = 2'(f); cfg_psc = 2'(p); cfg_pol = 2'(pl);
    cap_in = 1'b0;
    tick(14);
    clr_flags();
    cfg_en = 1'b1;
    tick(2);
  endtask

  task automatic run_all();
    logic [CW-1:0] v0, keep, cval;
    logic lvl;
    int ev, dv, nf;
    bit qual, expc;

    rst_n = 1'b0; cfg_mode = 1'b0; cfg_en = 1'b0; cfg_pol = 2'b00;
    cfg_flt = 2'b00; cfg_psc = 2'b00; ccr_wr = 1'b0; ccr_wdata = '0;
    cap_in = 1'b0; flag_clr = 1'b0;
    tick(3);
    // R12
    check(ccr_q == '0, "R12", "ccr_q in reset", ccr_q, 0);
    check(cap_flag == 1'b0 && ovr_flag == 1'b0, "R12", "flags in reset", {cap_flag, ovr_flag}, 0);
    check(pwm_out == 1'b0, "R12", "pwm_out in reset", pwm_out, 0);
    rst_n = 1'b1;
    tick(4);

    // R3 R4 R5: sweep of filter, prescaler and polarity
    for (int f = 0; f < 4; f++)
      for (int p = 0; p < 4; p++)
        for (int pl = 0; pl < 4; pl++) begin
          disarm_setup(f, p, pl);
          nf = 1 << f; dv = 1 << p; ev = 0; lvl = 1'b0;
          for (int t = 0; t < 6; t++) begin
            lvl = ~lvl;
            drive_pin(lvl, v0);
            tick(20);
            qual = pl[1] ? 1'b1 : (pl[0] ? !lvl : lvl);
            if (qual) ev++;
            expc = qual && (ev % dv == 0);
            check(cap_flag == expc, "R4/R5", "capture event", cap_flag, expc);
            if (expc)
              check(ccr_q == CW'(v0 + 3 + nf), "R3", "captured value", ccr_q, CW'(v0 + 3 + nf));
            clr_flags();
          end
          // R1
          check(pwm_out == 1'b0, "R1", "pwm_out in capture mode", pwm_out, 0);
        end

    // R2: glitch one cycle short is dropped, exact length passes
    for (int f = 1; f < 4; f++)
      for (int w0 = 0; w0 < 2; w0++) begin
        int w;
        nf = 1 << f;
        w = nf - 1 + w0;
        disarm_setup(f, 0, 2);
        @(negedge clk) cap_in = 1'b1;
        repeat (w) @(negedge clk);
        cap_in = 1'b0;
        tick(20);
        check(cap_flag == w0[0], "R2", "filter pulse length", cap_flag, w0);
        clr_flags();
      end

    // R6: prescaler restart on setting change
    disarm_setup(0, 3, 0);
    for (int t = 0; t < 3; t++) begin
      drive_pin(1'b1, v0); tick(10);
      drive_pin(1'b0, v0); tick(10);
    end
    cfg_psc = 2'd1;
    tick(4);
    drive_pin(1'b1, v0); tick(10);
    check(cap_flag == 1'b0, "R6", "first event after psc change", cap_flag, 0);
    drive_pin(1'b0, v0); tick(10);
    drive_pin(1'b1, v0); tick(10);
    check(cap_flag == 1'b1, "R6", "second event after psc change", cap_flag, 1);
    drive_pin(1'b0, v0); tick(10);
    clr_flags();

    // R9: overrun
    disarm_setup(0, 0, 2);
    drive_pin(1'b1, v0); tick(10);
    check(cap_flag == 1'b1 && ovr_flag == 1'b0, "R9", "single capture no overrun", {cap_flag, ovr_flag}, 2);
    drive_pin(1'b0, v0); tick(10);
    check(ovr_flag == 1'b1, "R9", "overrun after second capture", ovr_flag, 1);
    clr_flags();
    tick(1);
    // R8
    check(cap_flag == 1'b0 && ovr_flag == 1'b0, "R8", "flags cleared", {cap_flag, ovr_flag}, 0);

    // R7: disabled channel ignores edges
    disarm_setup(0, 0, 2);
    cfg_en = 1'b0;
    tick(2);
    keep = ccr_q;
    drive_pin(1'b1, v0); tick(10);
    drive_pin(1'b0, v0); tick(10);
    check(cap_flag == 1'b0, "R7", "no flag while disabled", cap_flag, 0);
    check(ccr_q == keep, "R7", "ccr_q held while disabled", ccr_q, keep);

    // R11 R10: compare mode
    @(negedge clk) cfg_mode = 1'b0; cfg_en = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      cval = (k == 0) ? CW'(cnt_val + 25) : '0;
      ccr_wr = 1'b1; ccr_wdata = cval;
      @(negedge clk) ccr_wr = 1'b0;
      check(ccr_q == cval, "R11", "register load", ccr_q, cval);
      for (int pl = 0; pl < 4; pl++) begin
        cfg_pol = 2'(pl);
        tick(2);
        for (int c = 0; c < 12; c++) begin
          bit e;
          e = (cnt_val < cval) ^ pl[0];
          check(pwm_out == e, "R10", "pwm level", pwm_out, e);
          @(negedge clk);
        end
      end
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule